// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns the operation field and the function field of a 32-bit instruction into the control points that steer a single-cycle datapath. It covers seven operations: add, subtract, immediate OR, word load, word store, branch-on-equal and unconditional jump. It drives these control points:

- destination-register choice
- second ALU operand source
- write-back source
- register-file write enable
- data-memory write enable
- branch select
- jump select
- immediate extension mode
- a 2-bit ALU operation code

Each supported instruction is recognised by a full-width equality match on the operation field. For register-type instructions the function field is matched as well. Each control point is then an OR of the instruction terms that need it. Any encoding that is not recognised leaves every output at 0, so nothing is written and the program counter is not redirected.

The decode is registered: the outputs show the fields that were sampled at the previous rising clock edge. A synchronous active-high reset clears every output. No datapath, register file or memory is part of the block.

Top module: `instr_ctl_dec`

## Requirements
- R1: Operation 000000 with function 100000 (add) gives dst_rd=1, rf_we=1 and alu_op=00 (00 add, 01 subtract, 10 OR). Every other output is 0.
- R2: Operation 000000 with function 100010 (subtract) gives dst_rd=1, rf_we=1 and alu_op=01. Every other output is 0.
- R3: Operation 001101 (immediate OR) gives b_imm=1, rf_we=1, imm_sext=0 (zero extension) and alu_op=10. Every other output is 0, so the destination is the rt field.
- R4: Operation 100011 (load) gives b_imm=1, wb_mem=1, rf_we=1, imm_sext=1 and alu_op=00. Every other output is 0.
- R5: Operation 101011 (store) gives b_imm=1, dm_we=1, imm_sext=1 and alu_op=00. Every other output is 0, and rf_we is 0 in particular.
- R6: Operation 000100 (branch-on-equal) gives br_sel=1 and alu_op=01. Every other output is 0.
- R7: Operation 000010 (jump) gives jmp_sel=1. Every other output is 0.
- R8: For the five operations other than 000000, the function field has no effect on any output.
- R9: Any operation outside the seven above, and operation 000000 with a function other than 100000 or 100010, drives every output to 0.
- R10: Outputs are registered. They reflect the fields sampled at the previous rising edge, and they stay unchanged until the next rising edge. A high rst at a rising edge sets every output to 0.
- R11: At most one of rf_we, dm_we, br_sel and jmp_sel is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | OP_W (6) | Operation field, instruction bits 31:26 |
| fn_i | input | FN_W (6) | Function field, instruction bits 5:0 |
| dst_rd | output | 1 | 1: write to the rd field, 0: write to the rt field |
| b_imm | output | 1 | 1: ALU second operand is the extended immediate |
| wb_mem | output | 1 | 1: write-back data comes from memory |
| rf_we | output | 1 | Register-file write enable |
| dm_we | output | 1 | Data-memory write enable |
| br_sel | output | 1 | Select the branch target on equality |
| jmp_sel | output | 1 | Select the jump target |
| imm_sext | output | 1 | 1: sign-extend the immediate, 0: zero-extend it |
| alu_op | output | 2 | ALU code: 00 add, 01 subtract, 10 OR |

## Verification
The bench builds the block with its default widths, OP_W=6 and FN_W=6. With these widths the whole input space is only 4096 operation/function pairs, so every pair is applied and compared against a behavioural table. The sweep therefore reaches every legal encoding, every illegal function under operation 000000, and every function value under each non-register operation. Separate steps check the one-cycle hold of the registered outputs and the clearing effect of a reset asserted while a load is being decoded.

// File: rtl/ictl_pkg.sv
package ictl_pkg;
  localparam int ALU_W = 2;
  localparam int NTERM = 7;
  localparam int T_ADD = 0;
  localparam int T_SUB = 1;
  localparam int T_ORI = 2;
  localparam int T_LD  = 3;
  localparam int T_ST  = 4;
  localparam int T_BEQ = 5;
  localparam int T_JMP = 6;

  typedef enum logic [ALU_W-1:0] {
    ALU_ADD = 2'b00,
    ALU_SUB = 2'b01,
    ALU_OR  = 2'b10
  } alu_op_e;

  typedef struct packed {
    logic            dst_rd;
    logic            b_imm;
    logic            wb_mem;
    logic            rf_we;
    logic            dm_we;
    logic            br_sel;
    logic            jmp_sel;
    logic            imm_sext;
    logic [ALU_W-1:0] alu_op;
  } ctl_t;

  // operation code each term matches
  function automatic logic [5:0] term_op(input int k);
    case (k)
      T_ADD, T_SUB: term_op = 6'b000000;
      T_ORI:        term_op = 6'b001101;
      T_LD:         term_op = 6'b100011;
      T_ST:         term_op = 6'b101011;
      T_BEQ:        term_op = 6'b000100;
      default:      term_op = 6'b000010;
    endcase
  endfunction

  function automatic logic term_uses_fn(input int k);
    term_uses_fn = (k == T_ADD) || (k == T_SUB);
  endfunction

  function automatic logic [5:0] term_fn(input int k);
    term_fn = (k == T_SUB) ? 6'b100010 : 6'b100000;
  endfunction
endpackage

// File: rtl/ictl_match.sv
module ictl_match
  import ictl_pkg::*;
#(
  parameter int OP_W = 6,
  parameter int FN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  op_i,
  input  logic [FN_W-1:0]  fn_i,
  output logic [NTERM-1:0] hit_o
);
  for (genvar k = 0; k < NTERM; k++) begin : g_term
    logic op_eq;
    logic fn_ok;
    assign op_eq = (op_i == OP_W'(term_op(k)));
    if (term_uses_fn(k)) begin : g_fn
      assign fn_ok = (fn_i == FN_W'(term_fn(k)));
    end else begin : g_nofn
      assign fn_ok = 1'b1;
    end
    assign hit_o[k] = op_eq & fn_ok;
  end

  // R9
  term_unique_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_o));
endmodule

// File: rtl/ictl_encode.sv
module ictl_encode
  import ictl_pkg::*;
(
  input  logic [NTERM-1:0] hit_i,
  output ctl_t             ctl_o
);
  always_comb begin
    ctl_o          = '0;
    ctl_o.dst_rd   = hit_i[T_ADD] | hit_i[T_SUB];
    ctl_o.b_imm    = hit_i[T_ORI] | hit_i[T_LD] | hit_i[T_ST];
    ctl_o.wb_mem   = hit_i[T_LD];
    ctl_o.rf_we    = hit_i[T_ADD] | hit_i[T_SUB] | hit_i[T_ORI] | hit_i[T_LD];
    ctl_o.dm_we    = hit_i[T_ST];
    ctl_o.br_sel   = hit_i[T_BEQ];
    ctl_o.jmp_sel  = hit_i[T_JMP];
    ctl_o.imm_sext = hit_i[T_LD] | hit_i[T_ST];
    ctl_o.alu_op[0] = hit_i[T_SUB] | hit_i[T_BEQ];
    ctl_o.alu_op[1] = hit_i[T_ORI];
  end
endmodule

// File: rtl/ictl_outreg.sv
module ictl_outreg
  import ictl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  ctl_t d_i,
  output ctl_t q_o
);
  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= d_i;
  end

  // R10
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (q_o == '0));

  // R11
  one_effect_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({q_o.rf_we, q_o.dm_we, q_o.br_sel, q_o.jmp_sel}) <= 1);
endmodule

// File: rtl/instr_ctl_dec.sv
module instr_ctl_dec
  import ictl_pkg::*;
#(
  parameter int OP_W = 6,
  parameter int FN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  op_i,
  input  logic [FN_W-1:0]  fn_i,
  output logic             dst_rd,
  output logic             b_imm,
  output logic             wb_mem,
  output logic             rf_we,
  output logic             dm_we,
  output logic             br_sel,
  output logic             jmp_sel,
  output logic             imm_sext,
  output logic [ALU_W-1:0] alu_op
);
  logic [NTERM-1:0] hit;
  ctl_t             ctl_d;
  ctl_t             ctl_q;

  ictl_match #(.OP_W(OP_W), .FN_W(FN_W)) u_match (
    .clk(clk), .rst(rst), .op_i(op_i), .fn_i(fn_i), .hit_o(hit)
  );

  ictl_encode u_enc (.hit_i(hit), .ctl_o(ctl_d));

  ictl_outreg u_reg (.clk(clk), .rst(rst), .d_i(ctl_d), .q_o(ctl_q));

  assign dst_rd   = ctl_q.dst_rd;
  assign b_imm    = ctl_q.b_imm;
  assign wb_mem   = ctl_q.wb_mem;
  assign rf_we    = ctl_q.rf_we;
  assign dm_we    = ctl_q.dm_we;
  assign br_sel   = ctl_q.br_sel;
  assign jmp_sel  = ctl_q.jmp_sel;
  assign imm_sext = ctl_q.imm_sext;
  assign alu_op   = ctl_q.alu_op;

  // R9
  unknown_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (hit == '0) |=> ({rf_we, dm_we, br_sel, jmp_sel, alu_op} == '0));

  // R5
  store_nowb_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_W'(6'b101011)) |=> (dm_we && !rf_we && imm_sext));

  // R6
  branch_sub_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_W'(6'b000100)) |=> (br_sel && alu_op == 2'b01 && !rf_we));

  // R7
  jump_only_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_W'(6'b000010)) |=> (jmp_sel && !dm_we && !rf_we && !br_sel));
endmodule

// File: tb/tb_instr_ctl_dec.sv
module tb_instr_ctl_dec;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] op_i = '0;
  logic [5:0] fn_i = '0;
  logic dst_rd, b_imm, wb_mem, rf_we, dm_we, br_sel, jmp_sel, imm_sext;
  logic [1:0] alu_op;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_P/2) clk = ~clk;

  instr_ctl_dec dut (
    .clk(clk), .rst(rst), .op_i(op_i), .fn_i(fn_i),
    .dst_rd(dst_rd), .b_imm(b_imm), .wb_mem(wb_mem), .rf_we(rf_we),
    .dm_we(dm_we), .br_sel(br_sel), .jmp_sel(jmp_sel),
    .imm_sext(imm_sext), .alu_op(alu_op)
  );

  // bit order: dst_rd b_imm wb_mem rf_we dm_we br_sel jmp_sel imm_sext alu_op[1:0]
  function automatic logic [9:0] model(input int op, input int fn);
    case (op)
      0: begin
        if (fn == 32)      model = 10'b1001000000;
        else if (fn == 34) model = 10'b1001000001;
        else               model = 10'b0;
      end
      13:      model = 10'b0101000010;
      35:      model = 10'b0111000100;
      43:      model = 10'b0100100100;
      4:       model = 10'b0000010001;
      2:       model = 10'b0000001000;
      default: model = 10'b0;
    endcase
  endfunction

  function automatic string tag(input int op, input int fn);
    case (op)
      0:  tag = (fn == 32) ? "R1" : (fn == 34) ? "R2" : "R9";
      13: tag = (fn != 0) ? "R8" : "R3";
      35: tag = (fn != 0) ? "R8" : "R4";
      43: tag = (fn != 0) ? "R8" : "R5";
      4:  tag = (fn != 0) ? "R8" : "R6";
      2:  tag = (fn != 0) ? "R8" : "R7";
      default: tag = "R9";
    endcase
  endfunction

  function automatic logic [9:0] outs();
    outs = {dst_rd, b_imm, wb_mem, rf_we, dm_we, br_sel, jmp_sel, imm_sext, alu_op};
  endfunction

  task automatic check(input string req, input logic [9:0] exp);
    checks++;
    if (outs() !== exp) begin
      fails++;
      $display("FAIL %s got=%b exp=%b", req, outs(), exp);
    end
  endtask

  task automatic check_r11();
    checks++;
    if ($countones({rf_we, dm_we, br_sel, jmp_sel}) > 1) begin
      fails++;
      $display("FAIL R11 got=%b exp=at most one set", {rf_we, dm_we, br_sel, jmp_sel});
    end
  endtask

  initial begin
    op_i = 6'd0; fn_i = 6'd32;
    repeat (3) @(negedge clk);
    check("R10", 10'b0);              // reset clears outputs
    rst = 1'b0;
    // full sweep, one pair per clock
    for (int op = 0; op < 64; op++) begin
      for (int fn = 0; fn < 64; fn++) begin
        op_i = 6'(op); fn_i = 6'(fn);
        @(negedge clk);
        check(tag(op, fn), model(op, fn));
        check_r11();
      end
    end
    // R10 hold: new fields do not show before the next rising edge
    op_i = 6'd35; fn_i = 6'd0;
    @(negedge clk);
    op_i = 6'd43;
    #1;
    check("R10", model(35, 0));
    @(negedge clk);
    check("R5", model(43, 0));
    // R10 reset while a load is presented
    op_i = 6'd35; rst = 1'b1;
    @(negedge clk);
    check("R10", 10'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R4", model(35, 0));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog got=timeout exp=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule